// File: doc/BRIEF.md
# Tile Row Chunk Extractor

This block keeps a small two-dimensional tile in flip-flops and returns a 64-byte slice of any one row as a 512-bit vector. The bytes are copied unchanged. A request carries one packed 32-bit selector word. Its low half names the row, and its high half names which 64-byte chunk of that row is wanted. Two configuration inputs describe the tile: the number of valid rows and the width of each row in bytes. Any output byte that falls outside the configured tile is returned as zero. The tile is filled one whole row at a time through a write port.

Requests arrive on a valid/ready handshake. The answer comes from a register on a second valid/ready handshake. An output state machine has two states. In EMPTY the output register holds nothing. In FULL it holds a response that is waiting to be taken. The machine has four transitions:
- FILL goes from EMPTY to FULL when a request is accepted.
- REFILL stays in FULL when the held response is taken and a new request is accepted in the same cycle.
- HOLD stays in FULL while the response waits with ready low.
- DRAIN goes from FULL to EMPTY when the response is taken and no request is accepted.

Because REFILL exists, the block can accept one request every cycle.

Top module: `tile_row_chunk_extractor`

## Requirements
- R1: The row index is `req_sel[15:0]` and the chunk number is `req_sel[31:16]`. The first row byte of the chunk is the chunk number times 64. A chunk whose bytes all lie at or above the row width returns an all-zero vector.
- R2: Output byte i (bits 8i+7:8i, i from 0 to 63) equals the byte at position chunk*64+i of the selected row, provided that position is below the effective row width. Row byte j is taken from `wr_data[8j+7:8j]` when the row is written.
- R3: Any output byte whose row position is at or above the effective row width is zero. The effective row width is `cfg_colsb`, limited to 64. A width of 0 gives an all-zero vector, and a value above 64 behaves as 64.
- R4: A row index at or above the effective row count gives an all-zero vector. The effective row count is `cfg_rows`, limited to 16.
- R5: When `wr_en` is high, `wr_data` is written into row `wr_row` at the clock edge. A request accepted in the same cycle as a write to the same row returns the contents from before the write.
- R6: A request accepted at one clock edge makes `rsp_valid` high after that edge, with its data. While `rsp_ready` is low, `rsp_valid` and `rsp_data` stay unchanged.
- R7: `req_ready` is high whenever the output is empty or `rsp_ready` is high. This allows one accepted request per cycle, back to back.
- R8: After reset, `rsp_valid` is low, `rsp_data` is zero and every tile byte reads as zero.
- R9: The selector, configuration and tile contents are captured when a request is accepted. Later changes to any of them do not alter a response that is being held.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| wr_en | input | 1 | Write one whole tile row |
| wr_row | input | 4 | Row to write |
| wr_data | input | 512 | Row contents, byte j in bits 8j+7:8j |
| cfg_rows | input | 5 | Number of valid rows (limited to 16) |
| cfg_colsb | input | 7 | Row width in bytes (limited to 64) |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request accepted when high together with req_valid |
| req_sel | input | 32 | Packed selector: chunk in 31:16, row in 15:0 |
| rsp_valid | output | 1 | Response register holds a result |
| rsp_ready | input | 1 | Downstream takes the response |
| rsp_data | output | 512 | Extracted and masked chunk |

## Verification
Two functions can fall in the same cycle: a row write through the write port, and an accepted read of that same row. The bench provokes this by raising `wr_en` and `req_valid` for one row in a single cycle, both directly and at random during a long mixed stream. Its behavioural model answers every read from its byte array before applying that cycle's write. The response is therefore judged to carry the old row, and the read that follows is judged to carry the new one. The same stream also lines up a DRAIN with a new request in one cycle, so REFILL is exercised under random `rsp_ready`.

// File: rtl/tre_pkg.sv
package tre_pkg;

    // Two states of the response register
    typedef enum logic [0:0] {
        OS_EMPTY = 1'b0,
        OS_FULL  = 1'b1
    } out_state_t;

endpackage

// File: rtl/tre_tile_store.sv
module tre_tile_store #(
    parameter int ROWS      = 16,
    parameter int ROW_BYTES = 64
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       wr_en,
    input  logic [$clog2(ROWS)-1:0]    wr_row,
    input  logic [ROW_BYTES*8-1:0]     wr_data,
    input  logic [$clog2(ROWS)-1:0]    rd_row,
    output logic [ROW_BYTES*8-1:0]     rd_data
);
    localparam int RW = ROW_BYTES * 8;

    logic [RW-1:0] row_q [ROWS];

    for (genvar r = 0; r < ROWS; r++) begin : g_row
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                row_q[r] <= '0;
            end else if (wr_en && (int'(wr_row) == r)) begin
                row_q[r] <= wr_data;
            end
        end
    end

    // Read is taken before this cycle's write lands
    assign rd_data = row_q[rd_row];

    // R5
    write_lands_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> (row_q[$past(wr_row)] == $past(wr_data)));

endmodule

// File: rtl/tre_chunk_mask.sv
module tre_chunk_mask #(
    parameter int ROWS        = 16,
    parameter int ROW_BYTES   = 64,
    parameter int CHUNK_BYTES = 64
) (
    input  logic [31:0]                    sel,
    input  logic [$clog2(ROWS+1)-1:0]      cfg_rows,
    input  logic [$clog2(ROW_BYTES+1)-1:0] cfg_colsb,
    input  logic [ROW_BYTES*8-1:0]         row_data,
    output logic [$clog2(ROWS)-1:0]        rd_row,
    output logic [CHUNK_BYTES*8-1:0]       chunk_data
);
    localparam int RCW    = $clog2(ROWS + 1);
    localparam int CSW    = $clog2(ROW_BYTES + 1);
    localparam int RIW    = $clog2(ROWS);
    localparam int NCHUNK = ROW_BYTES / CHUNK_BYTES;
    localparam int CW     = CHUNK_BYTES * 8;

    logic [15:0]     row_full;
    logic [15:0]     chunk_num;
    logic [RCW-1:0]  rows_eff;
    logic [CSW-1:0]  colsb_eff;
    logic            row_ok;
    logic [31:0]     offset;
    logic [CW-1:0]   slice;

    assign row_full  = sel[15:0];
    assign chunk_num = sel[31:16];
    assign rd_row    = row_full[RIW-1:0];

    always_comb begin
        rows_eff  = (cfg_rows  > RCW'(ROWS))      ? RCW'(ROWS)      : cfg_rows;
        colsb_eff = (cfg_colsb > CSW'(ROW_BYTES)) ? CSW'(ROW_BYTES) : cfg_colsb;
        row_ok    = row_full < 16'(rows_eff);
        offset    = 32'(chunk_num) * 32'(CHUNK_BYTES);
    end

    if (NCHUNK == 1) begin : g_one_chunk
        assign slice = row_data[CW-1:0];
    end else begin : g_many_chunks
        localparam int IW = $clog2(NCHUNK);
        logic [IW-1:0] idx;
        assign idx   = chunk_num[IW-1:0];
        assign slice = row_data[int'(idx)*CW +: CW];
    end

    for (genvar i = 0; i < CHUNK_BYTES; i++) begin : g_byte
        logic in_width;
        assign in_width = (offset + 32'(i)) < 32'(colsb_eff);
        assign chunk_data[i*8 +: 8] = (row_ok && in_width) ? slice[i*8 +: 8] : 8'h00;
    end

endmodule

// File: rtl/tre_out_stage.sv
module tre_out_stage
    import tre_pkg::*;
#(
    parameter int DW = 512
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          req_valid,
    output logic          req_ready,
    input  logic [DW-1:0] din,
    output logic          rsp_valid,
    input  logic          rsp_ready,
    output logic [DW-1:0] rsp_data
);
    out_state_t state_q, state_d;
    logic       accept;

    assign req_ready = (state_q == OS_EMPTY) || rsp_ready;
    assign accept    = req_valid && req_ready;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            OS_EMPTY: if (accept) state_d = OS_FULL;                   // FILL
            OS_FULL:  if (rsp_ready && !accept) state_d = OS_EMPTY;    // DRAIN (REFILL/HOLD stay)
            default:  state_d = OS_EMPTY;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= OS_EMPTY;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      rsp_data <= '0;
        else if (accept) rsp_data <= din;
    end

    assign rsp_valid = (state_q == OS_FULL);

    // R6
    hold_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(rsp_data)));

    // R6
    accept_fills_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready) |=> rsp_valid);

    // R7
    ready_when_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !rsp_valid |-> req_ready);

    // R7
    drain_empties_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && rsp_ready && !req_valid) |=> !rsp_valid);

endmodule

// File: rtl/tile_row_chunk_extractor.sv
module tile_row_chunk_extractor #(
    parameter int ROWS        = 16,
    parameter int ROW_BYTES   = 64,
    parameter int CHUNK_BYTES = 64
) (
    input  logic                            clk,
    input  logic                            rst_n,
    input  logic                            wr_en,
    input  logic [$clog2(ROWS)-1:0]         wr_row,
    input  logic [ROW_BYTES*8-1:0]          wr_data,
    input  logic [$clog2(ROWS+1)-1:0]       cfg_rows,
    input  logic [$clog2(ROW_BYTES+1)-1:0]  cfg_colsb,
    input  logic                            req_valid,
    output logic                            req_ready,
    input  logic [31:0]                     req_sel,
    output logic                            rsp_valid,
    input  logic                            rsp_ready,
    output logic [CHUNK_BYTES*8-1:0]        rsp_data
);
    localparam int RIW = $clog2(ROWS);
    localparam int CSW = $clog2(ROW_BYTES + 1);
    localparam int CW  = CHUNK_BYTES * 8;

    logic [RIW-1:0]       rd_row;
    logic [ROW_BYTES*8-1:0] row_data;
    logic [CW-1:0]        chunk_data;

    tre_tile_store #(.ROWS(ROWS), .ROW_BYTES(ROW_BYTES)) u_store (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_row  (wr_row),
        .wr_data (wr_data),
        .rd_row  (rd_row),
        .rd_data (row_data)
    );

    tre_chunk_mask #(.ROWS(ROWS), .ROW_BYTES(ROW_BYTES), .CHUNK_BYTES(CHUNK_BYTES)) u_mask (
        .sel        (req_sel),
        .cfg_rows   (cfg_rows),
        .cfg_colsb  (cfg_colsb),
        .row_data   (row_data),
        .rd_row     (rd_row),
        .chunk_data (chunk_data)
    );

    tre_out_stage #(.DW(CW)) u_out (
        .clk       (clk),
        .rst_n     (rst_n),
        .req_valid (req_valid),
        .req_ready (req_ready),
        .din       (chunk_data),
        .rsp_valid (rsp_valid),
        .rsp_ready (rsp_ready),
        .rsp_data  (rsp_data)
    );

    // R4
    row_range_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready && (req_sel[15:0] >= 16'(cfg_rows))) |=> (rsp_data == '0));

    // R3
    zero_width_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready && (cfg_colsb == '0)) |=> (rsp_data == '0));

    // R3
    beyond_width_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready && (cfg_colsb < CSW'(CHUNK_BYTES)))
            |=> ((rsp_data >> {$past(cfg_colsb), 3'b000}) == '0));

endmodule

// File: tb/sim_tile_row_chunk_extractor.sv
module sim_tile_row_chunk_extractor;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         wr_en = 1'b0;
    logic [3:0]   wr_row = '0;
    logic [511:0] wr_data = '0;
    logic [4:0]   cfg_rows = 5'd16;
    logic [6:0]   cfg_colsb = 7'd64;
    logic         req_valid = 1'b0;
    logic         req_ready;
    logic [31:0]  req_sel = '0;
    logic         rsp_valid;
    logic         rsp_ready = 1'b1;
    logic [511:0] rsp_data;

    int    n_checks = 0;
    int    n_fails  = 0;
    int    cycles   = 0;
    string tag      = "R8";

    // Behavioural model state
    byte unsigned mdl [16][64];
    bit           exp_valid;
    logic [511:0] exp_data;

    always #10 clk = ~clk;

    tile_row_chunk_extractor u0 (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_row(wr_row), .wr_data(wr_data),
        .cfg_rows(cfg_rows), .cfg_colsb(cfg_colsb), .req_valid(req_valid),
        .req_ready(req_ready), .req_sel(req_sel), .rsp_valid(rsp_valid),
        .rsp_ready(rsp_ready), .rsp_data(rsp_data)
    );

    function automatic logic [511:0] model_read(logic [31:0] sel, int rows, int colsb);
        logic [511:0] v = '0;
        int row   = int'(sel[15:0]);
        int chunk = int'(sel[31:16]);
        if (rows > 16) rows = 16;
        if (colsb > 64) colsb = 64;
        for (int i = 0; i < 64; i++) begin
            int pos = chunk * 64 + i;
            if (row < rows && pos < colsb) v[i*8 +: 8] = mdl[row][pos];
        end
        return v;
    endfunction

    function automatic logic [511:0] pattern(int r, int seed);
        logic [511:0] v;
        for (int j = 0; j < 64; j++) v[j*8 +: 8] = 8'((r * 37 + j * 11 + seed) & 255);
        return v;
    endfunction

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            exp_valid = 1'b0;
            exp_data  = '0;
            for (int r = 0; r < 16; r++) for (int j = 0; j < 64; j++) mdl[r][j] = 8'h00;
        end else begin
            if (req_valid && (!exp_valid || rsp_ready)) begin
                exp_data  = model_read(req_sel, int'(cfg_rows), int'(cfg_colsb));
                exp_valid = 1'b1;
            end else if (rsp_ready) begin
                exp_valid = 1'b0;
            end
            if (wr_en) for (int j = 0; j < 64; j++) mdl[wr_row][j] = wr_data[j*8 +: 8];
        end
    end

    task automatic check_bit(string what, logic act, logic expv);
        n_checks++;
        if (act !== expv) begin
            n_fails++;
            $display("FAIL %s %s: actual %0b expected %0b", tag, what, act, expv);
        end
    endtask

    task automatic check_vec(string what, logic [511:0] act, logic [511:0] expv);
        n_checks++;
        if (act !== expv) begin
            n_fails++;
            $display("FAIL %s %s: actual %h expected %h", tag, what, act, expv);
        end
    endtask

    // Compare on every cycle, away from the active edge
    always @(negedge clk) begin
        if (rst_n) begin
            check_bit("req_ready", req_ready, !exp_valid || rsp_ready);
            check_bit("rsp_valid", rsp_valid, exp_valid);
            if (exp_valid) check_vec("rsp_data", rsp_data, exp_data);
        end
    end

    always @(posedge clk) begin
        cycles++;
        if (cycles > 20000) begin
            n_fails++;
            $display("FAIL watchdog: actual %0d cycles expected under 20000", cycles);
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
            $finish;
        end
    end

    task automatic step();
        @(negedge clk);
        #2;
    endtask

    task automatic rd(logic [15:0] chunk, logic [15:0] row);
        req_valid = 1'b1;
        req_sel   = {chunk, row};
        step();
        req_valid = 1'b0;
    endtask

    initial begin
        // R8: reset state
        step();
        check_bit("rsp_valid in reset", rsp_valid, 1'b0);
        check_vec("rsp_data in reset", rsp_data, '0);
        step();
        rst_n = 1'b1;
        step();
        tag = "R8";
        rd(16'd0, 16'd3);
        rd(16'd0, 16'd15);

        // R2: full rows
        tag = "R2";
        for (int r = 0; r < 16; r++) begin
            wr_en = 1'b1; wr_row = 4'(r); wr_data = pattern(r, 5);
            step();
        end
        wr_en = 1'b0;
        for (int r = 0; r < 16; r++) rd(16'd0, 16'(r));

        // R1: selector decode
        tag = "R1";
        rd(16'd0, 16'h0107);
        rd(16'd1, 16'd2);
        rd(16'hFFFF, 16'd2);
        rd(16'd0, 16'd7);

        // R3: row width masking
        tag = "R3";
        foreach (cfg_colsb_vals[k]) begin
            cfg_colsb = cfg_colsb_vals[k];
            rd(16'd0, 16'd9);
        end
        cfg_colsb = 7'd64;

        // R4: row count
        tag = "R4";
        cfg_rows = 5'd5;  rd(16'd0, 16'd4); rd(16'd0, 16'd5);
        cfg_rows = 5'd0;  rd(16'd0, 16'd0);
        cfg_rows = 5'd20; rd(16'd0, 16'd15); rd(16'd0, 16'd17);
        cfg_rows = 5'd16;

        // R5: write and read of one row in one cycle
        tag = "R5";
        wr_en = 1'b1; wr_row = 4'd6; wr_data = pattern(6, 200);
        rd(16'd0, 16'd6);
        wr_en = 1'b0;
        rd(16'd0, 16'd6);

        // R6 and R9: hold under back-pressure with changing inputs
        tag = "R6";
        rsp_ready = 1'b0;
        rd(16'd0, 16'd8);
        tag = "R9";
        cfg_colsb = 7'd3; cfg_rows = 5'd1;
        wr_en = 1'b1; wr_row = 4'd8; wr_data = pattern(8, 99);
        req_valid = 1'b1; req_sel = 32'd1;
        step();
        wr_en = 1'b0;
        step();
        req_valid = 1'b0;
        step();
        rsp_ready = 1'b1;
        step();
        cfg_colsb = 7'd64; cfg_rows = 5'd16;

        // R7: back-to-back then random mixed traffic
        tag = "R7";
        req_valid = 1'b1;
        for (int k = 0; k < 8; k++) begin
            req_sel = {16'd0, 16'(k)};
            step();
        end
        req_valid = 1'b0;
        for (int k = 0; k < 400; k++) begin
            req_valid = 1'($urandom % 4 != 0);
            rsp_ready = 1'($urandom % 3 != 0);
            req_sel   = {(($urandom % 5) == 0) ? 16'd1 : 16'd0, 16'($urandom % 20)};
            cfg_colsb = 7'($urandom % 70);
            cfg_rows  = 5'($urandom % 18);
            wr_en     = 1'($urandom % 3 == 0);
            wr_row    = 4'(req_sel[3:0]);
            wr_data   = pattern(int'($urandom % 16), int'($urandom % 256));
            step();
        end
        wr_en = 1'b0; req_valid = 1'b0; rsp_ready = 1'b1;
        step();
        step();

        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
        $finish;
    end

    logic [6:0] cfg_colsb_vals [6] = '{7'd0, 7'd1, 7'd17, 7'd63, 7'd64, 7'd100};

endmodule